// File: doc/BRIEF.md
# Multi-Mode Multiply-Accumulate Unit

This block multiplies two 16-bit operands and merges the 32-bit product into a 40-bit accumulator value. The product is either added to or subtracted from the accumulator value, and the choice is made per operation. The operands can be treated as both signed, as signed times unsigned, or as both unsigned. Before it is merged, the 40-bit accumulator value can pass through unchanged or be shifted right arithmetically by one bit or by sixteen bits.

A datapath controller presents both operands, the accumulator value and the mode fields together with a one-cycle valid strobe. The result appears in a register on the next clock edge, and the output valid flag is high in that same cycle. By convention the signed operand is taken from the upper half-word of a source register and the unsigned operand from the lower half-word. The block receives the half-words already extracted. The arithmetic wraps modulo 2^40. There is no saturation, no rounding and no overflow reporting.

Top module: `mac_unit`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `result` carries the value for that operation after that edge and `out_valid` is high for exactly that cycle.
- R2: When `in_valid` is low at a rising clock edge, `out_valid` is low after that edge and `result` keeps its previous value, whatever the other inputs do.
- R3: While `rst_n` is low, `result` is zero and `out_valid` is low.
- R4: `sign_mode` = 2'b00 treats `op_a` and `op_b` as two's complement values.
- R5: `sign_mode` = 2'b01 treats `op_a` as two's complement and `op_b` as unsigned.
- R6: `sign_mode` = 2'b10 treats both operands as unsigned. The code 2'b11 behaves the same way.
- R7: `sub_en` = 1 gives the shifted accumulator value minus the product. `sub_en` = 0 gives their sum.
- R8: `pre_shift` = 2'b01 shifts `addend` right arithmetically by 1 bit before it is merged, and 2'b10 shifts it by 16 bits. The codes 2'b00 and 2'b11 use `addend` unshifted.
- R9: The merge wraps modulo 2^40. For example, 0x7FFFFFFFFF plus 1 gives 0x8000000000, and 0 minus 1 gives 0xFFFFFFFFFF.
- R10: In unsigned modes the product is zero-extended to 40 bits. In the other modes it is sign-extended. With a zero accumulator value, no shift and addition, an unsigned product leaves bits 39:32 at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe, one cycle per operation |
| op_a | input | 16 | First multiplier operand (signed unless unsigned mode) |
| op_b | input | 16 | Second multiplier operand |
| addend | input | 40 | Accumulator value merged with the product |
| sign_mode | input | 2 | 00 signed x signed, 01 signed x unsigned, 10/11 unsigned x unsigned |
| sub_en | input | 1 | 1 subtracts the product, 0 adds it |
| pre_shift | input | 2 | 00/11 none, 01 arithmetic right by 1, 10 arithmetic right by 16 |
| out_valid | output | 1 | High in the cycle after an accepted operation |
| result | output | 40 | Registered 40-bit result |

## Verification
On every cycle, the assertions check the one-cycle latency of the valid flag, that the result is held and the valid flag stays low on idle cycles, that the output clears during reset, and two arithmetic identities. The first identity is that a zero first operand with no shift passes the accumulator value through. The second is that an unsigned product added to zero never reaches bits 39:32. Whether each signedness mode, shift amount and subtract choice produces the exact 40-bit value, including wraparound at the extreme operand values, can only be shown by the bench's sweep. That sweep compares every combination of edge-case operands, modes, shifts and accumulator values against an arithmetic model.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [1:0] {
        SGN_SS  = 2'b00,
        SGN_SU  = 2'b01,
        SGN_UU  = 2'b10,
        SGN_UU2 = 2'b11
    } sign_mode_e;

    typedef enum logic [1:0] {
        SHF_NONE  = 2'b00,
        SHF_ONE   = 2'b01,
        SHF_LONG  = 2'b10,
        SHF_NONE2 = 2'b11
    } shift_sel_e;

    // Operand index constants used by the extension generate loop.
    localparam int unsigned OPND_A = 0;
    localparam int unsigned OPND_B = 1;
    localparam int unsigned OPND_N = 2;

endpackage

// File: rtl/mac_operand_ext.sv
// Widens a raw operand by one bit so that signed and unsigned values
// share one signed multiplier.
module mac_operand_ext #(
    parameter int unsigned OP_W = 16
) (
    input  logic [OP_W-1:0]   raw,
    input  logic              is_signed,
    output logic signed [OP_W:0] ext
);
    logic top_bit;

    always_comb begin
        top_bit = is_signed & raw[OP_W-1];
        ext     = $signed({top_bit, raw});
    end
endmodule

// File: rtl/mac_mult.sv
// Signed (OP_W+1) x (OP_W+1) multiply, resized to ACC_W with sign extension.
module mac_mult #(
    parameter int unsigned OP_W  = 16,
    parameter int unsigned ACC_W = 40
) (
    input  logic signed [OP_W:0] a_ext,
    input  logic signed [OP_W:0] b_ext,
    output logic [ACC_W-1:0]     prod
);
    localparam int unsigned PW = 2 * OP_W + 2;

    logic signed [PW-1:0] a_w;
    logic signed [PW-1:0] b_w;
    logic signed [PW-1:0] p_full;

    always_comb begin
        a_w    = $signed({{(PW-OP_W-1){a_ext[OP_W]}}, a_ext});
        b_w    = $signed({{(PW-OP_W-1){b_ext[OP_W]}}, b_ext});
        p_full = a_w * b_w;
    end

    generate
        if (ACC_W > PW) begin : g_widen
            assign prod = {{(ACC_W-PW){p_full[PW-1]}}, p_full};
        end else begin : g_trunc
            assign prod = p_full[ACC_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/mac_preshift.sv
// Selects the unshifted, 1-bit or long arithmetic right shift of the addend.
module mac_preshift #(
    parameter int unsigned ACC_W   = 40,
    parameter int unsigned LONG_SH = 16
) (
    input  logic [ACC_W-1:0]  value,
    input  mac_pkg::shift_sel_e sel,
    output logic [ACC_W-1:0]  shifted
);
    import mac_pkg::*;

    logic [ACC_W-1:0] sh_one;
    logic [ACC_W-1:0] sh_long;

    always_comb begin
        sh_one  = {value[ACC_W-1], value[ACC_W-1:1]};
        sh_long = {{LONG_SH{value[ACC_W-1]}}, value[ACC_W-1:LONG_SH]};
        unique case (sel)
            SHF_ONE:  shifted = sh_one;
            SHF_LONG: shifted = sh_long;
            default:  shifted = value;
        endcase
    end
endmodule

// File: rtl/mac_combine.sv
// Adds or subtracts the product, wrapping modulo 2^ACC_W.
module mac_combine #(
    parameter int unsigned ACC_W = 40
) (
    input  logic [ACC_W-1:0] acc_in,
    input  logic [ACC_W-1:0] prod,
    input  logic             subtract,
    output logic [ACC_W-1:0] sum
);
    logic [ACC_W-1:0] prod_sel;

    always_comb begin
        prod_sel = subtract ? ~prod : prod;
        sum      = acc_in + prod_sel + {{(ACC_W-1){1'b0}}, subtract};
    end
endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
    parameter int unsigned OP_W    = 16,
    parameter int unsigned ACC_W   = 40,
    parameter int unsigned LONG_SH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    input  logic [ACC_W-1:0] addend,
    input  logic [1:0]       sign_mode,
    input  logic             sub_en,
    input  logic [1:0]       pre_shift,
    output logic             out_valid,
    output logic [ACC_W-1:0] result
);
    import mac_pkg::*;

    typedef struct packed {
        logic             vld;
        logic [ACC_W-1:0] res;
    } out_state_t;

    out_state_t state_d;
    out_state_t state_q;

    sign_mode_e mode_sel;
    shift_sel_e shift_sel;
    logic [OPND_N-1:0]    opnd_signed;
    logic [OP_W-1:0]      opnd_raw [OPND_N];
    logic signed [OP_W:0] opnd_ext [OPND_N];
    logic [ACC_W-1:0]     prod_w;
    logic [ACC_W-1:0]     acc_shifted;
    logic [ACC_W-1:0]     merged;

    always_comb begin
        mode_sel  = sign_mode_e'(sign_mode);
        shift_sel = shift_sel_e'(pre_shift);
        unique case (mode_sel)
            SGN_SS:  opnd_signed = 2'b11;
            SGN_SU:  opnd_signed = 2'b01;
            default: opnd_signed = 2'b00;
        endcase
        opnd_raw[OPND_A] = op_a;
        opnd_raw[OPND_B] = op_b;
    end

    for (genvar gi = 0; gi < OPND_N; gi++) begin : g_ext
        mac_operand_ext #(.OP_W(OP_W)) ext_i (
            .raw       (opnd_raw[gi]),
            .is_signed (opnd_signed[gi]),
            .ext       (opnd_ext[gi])
        );
    end

    mac_mult #(.OP_W(OP_W), .ACC_W(ACC_W)) mult_i (
        .a_ext (opnd_ext[OPND_A]),
        .b_ext (opnd_ext[OPND_B]),
        .prod  (prod_w)
    );

    mac_preshift #(.ACC_W(ACC_W), .LONG_SH(LONG_SH)) shift_i (
        .value   (addend),
        .sel     (shift_sel),
        .shifted (acc_shifted)
    );

    mac_combine #(.ACC_W(ACC_W)) comb_i (
        .acc_in   (acc_shifted),
        .prod     (prod_w),
        .subtract (sub_en),
        .sum      (merged)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.res = merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign result    = state_q.res;
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
    parameter int unsigned OP_W  = 16,
    parameter int unsigned ACC_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [OP_W-1:0]  op_a,
    input logic [ACC_W-1:0] addend,
    input logic [1:0]       sign_mode,
    input logic             sub_en,
    input logic [1:0]       pre_shift,
    input logic             out_valid,
    input logic [ACC_W-1:0] result
);
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result))); // R2

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0)); // R3

    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_a == '0 && (pre_shift == 2'b00 || pre_shift == 2'b11))
        |=> result == $past(addend)); // R8

    AST_UU_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sign_mode[1] && addend == '0 && !sub_en && pre_shift == 2'b00)
        |=> (result >> (2 * OP_W)) == '0); // R10
endmodule

bind mac_unit mac_unit_chk #(.OP_W(OP_W), .ACC_W(ACC_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .addend    (addend),
    .sign_mode (sign_mode),
    .sub_en    (sub_en),
    .pre_shift (pre_shift),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/mac_unit_tb_top.sv
`timescale 1ns/1ps
module mac_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [39:0] addend = '0;
    logic [1:0]  sign_mode = '0;
    logic        sub_en = 1'b0;
    logic [1:0]  pre_shift = '0;
    logic        out_valid;
    logic [39:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mac_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .addend(addend), .sign_mode(sign_mode), .sub_en(sub_en),
        .pre_shift(pre_shift), .out_valid(out_valid), .result(result)
    );

    function automatic logic [39:0] model(input logic [15:0] a, input logic [15:0] b,
                                          input logic [1:0] m, input logic s,
                                          input logic [1:0] sh, input logic [39:0] ad);
        longint av, bv, acc, p, r;
        av  = (m == 2'b00 || m == 2'b01) ? longint'($signed(a)) : longint'({48'd0, a});
        bv  = (m == 2'b00) ? longint'($signed(b)) : longint'({48'd0, b});
        acc = longint'($signed(ad));
        if (sh == 2'b01) acc = acc >>> 1;
        else if (sh == 2'b10) acc = acc >>> 16;
        p = av * bv;
        r = s ? acc - p : acc + p;
        return r[39:0];
    endfunction

    task automatic check40(input string tag, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive at a falling edge; the result is registered at the next rising
    // edge and sampled at the falling edge after it.
    task automatic run_op(input string tag, input logic [15:0] a, input logic [15:0] b,
                          input logic [1:0] m, input logic s, input logic [1:0] sh,
                          input logic [39:0] ad);
        op_a = a; op_b = b; sign_mode = m; sub_en = s; pre_shift = sh; addend = ad;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check1({tag, " R1 valid"}, out_valid, 1'b1);
        check40(tag, result, model(a, b, m, s, sh, ad));
    endtask

    logic [15:0] opv [7] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
                             16'h8000, 16'h1234, 16'hA5C3};
    logic [39:0] adv [3] = '{40'h00_0000_0000, 40'h12_3456_789A, 40'hF0_0000_0001};

    initial begin
        #1 rst_n = 1'b0;
        in_valid = 1'b1; op_a = 16'h7FFF; op_b = 16'h7FFF; addend = 40'h1;
        repeat (3) @(negedge clk);
        check1("R3 reset valid", out_valid, 1'b0);
        check40("R3 reset result", result, '0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corner values
        run_op("R4 min*min", 16'h8000, 16'h8000, 2'b00, 1'b0, 2'b00, 40'h0);
        check40("R4 min*min value", result, 40'h00_4000_0000);
        run_op("R5 neg*unsigned", 16'hFFFF, 16'hFFFF, 2'b01, 1'b0, 2'b00, 40'h0);
        check40("R5 value", result, 40'hFF_FFFF_0001);
        run_op("R10 UU max", 16'hFFFF, 16'hFFFF, 2'b10, 1'b0, 2'b00, 40'h0);
        check40("R10 zero ext", result, 40'h00_FFFE_0001);
        run_op("R6 code 11", 16'hFFFF, 16'hFFFF, 2'b11, 1'b0, 2'b00, 40'h0);
        check40("R6 code 11 value", result, 40'h00_FFFE_0001);
        run_op("R9 wrap add", 16'h0001, 16'h0001, 2'b00, 1'b0, 2'b00, 40'h7F_FFFF_FFFF);
        check40("R9 wrap add value", result, 40'h80_0000_0000);
        run_op("R9 wrap sub", 16'h0001, 16'h0001, 2'b00, 1'b1, 2'b00, 40'h0);
        check40("R9 wrap sub value", result, 40'hFF_FFFF_FFFF);
        run_op("R7 sub", 16'h0003, 16'h0004, 2'b00, 1'b1, 2'b00, 40'd100);
        check40("R7 sub value", result, 40'd88);
        run_op("R8 shift16", 16'h0000, 16'h0000, 2'b00, 1'b0, 2'b10, 40'h80_0001_0000);
        check40("R8 shift16 value", result, 40'hFF_FF80_0001);
        run_op("R8 shift1", 16'h0000, 16'h0000, 2'b00, 1'b0, 2'b01, 40'hFF_FFFF_FFFF);
        check40("R8 shift1 value", result, 40'hFF_FFFF_FFFF);

        // Idle cycle: inputs change but nothing moves
        in_valid = 1'b0; op_a = 16'h5555; op_b = 16'h3333; addend = 40'h77;
        @(posedge clk);
        @(negedge clk);
        check1("R2 idle valid", out_valid, 1'b0);
        check40("R2 idle hold", result, 40'hFF_FFFF_FFFF);
        @(posedge clk);
        @(negedge clk);
        check40("R2 idle hold 2", result, 40'hFF_FFFF_FFFF);

        // Sweep: operand pairs x modes x subtract x shifts x accumulator values
        for (int ia = 0; ia < 7; ia++)
            for (int ib = 0; ib < 7; ib++)
                for (int m = 0; m < 4; m++)
                    for (int s = 0; s < 2; s++)
                        for (int sh = 0; sh < 4; sh++)
                            for (int k = 0; k < 3; k++)
                                run_op(m == 0 ? "R4 sweep" : (m == 1 ? "R5 sweep" : "R6 sweep"),
                                       opv[ia], opv[ib], 2'(m), 1'(s), 2'(sh), adv[k]);

        // Reset in mid-stream clears the output (R3)
        rst_n = 1'b0;
        #1;
        check1("R3 mid reset valid", out_valid, 1'b0);
        check40("R3 mid reset result", result, '0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check1("R2 after reset valid", out_valid, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule